// File: doc/BRIEF.md
# Paged-Index Serial Configuration Target

This block is a two-wire serial bus target that lets a host read and write a small bank of 8-bit configuration registers. The host addresses the target with a 7-bit address. Six bits of that address are fixed. The seventh comes from a strap input, so two copies of the block can share one bus. After the address, the host sends a register index. It then either writes data bytes, or issues a repeated START with the read bit set and clocks data bytes back out.

The register index is split into a page (upper nibble) and an offset (lower nibble). After every data byte, whether written or read, only the offset advances. A burst therefore wraps inside its 16-entry page and never spills into the next page. Twelve registers exist: offsets 0 to 8 of page 0 and offsets 0 to 2 of page 1. Their contents are presented in parallel to the core logic. Each accepted write is also announced by a one-cycle strobe that carries the index and the data.

SCL and SDA are brought into the system clock through two-flop synchronisers, and all bus events are detected on the synchronised values. The system clock must run at least ten times faster than SCL. SDA is modelled as open drain: the block only ever pulls the line low, through `sda_oe_o`.

Top module: `i2cr_target`

## Requirements
- R1: The target answers the 7-bit address 0b010011X, where X is the level of `addr_sel_i`, sent MSB first and followed by a R/W bit (0 = write, 1 = read). On a match it acknowledges by pulling SDA low for the ninth clock, and only changes its SDA drive while SCL is low.
- R2: On an address that does not match, the target does not acknowledge and leaves SDA released until the next START.
- R3: In a write, the byte after the address is the register index and every following byte is data. The target acknowledges each one. Each data byte sent to an implemented index updates that register and raises `wr_stb_o` for exactly one system cycle, with `wr_idx_o` and `wr_data_o` holding the index and the byte.
- R4: A read is an index write followed by a repeated START and the address with R/W = 1. The target then returns the register at the current index, MSB first.
- R5: While the host acknowledges a read byte, the target sends the next byte. After a NACK it releases SDA and drives nothing more until the next START.
- R6: After each data byte written or read, only the low 4 bits of the index increment, wrapping from 0xF to 0x0. The upper 4 bits change only when a new index byte is received.
- R7: Implemented indices are 0x00–0x08 and 0x10–0x12. Writes to any other index are acknowledged but change no register and raise no strobe. Reads from other indices return 0x00.
- R8: A START in any state restarts address reception. A STOP in any state returns the target to idle with SDA released, so bytes clocked after a STOP with no new START are not acknowledged.
- R9: On reset (`rst_n` low), the index is 0x00 and the register at index n holds n XOR 0x5A. `regs_o` holds slot s in bits [8s+7:8s]. Slots 0–8 are indices 0x00–0x08, and slots 9–11 are indices 0x10–0x12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sensed level of the serial data line |
| addr_sel_i | input | 1 | Strap giving the lowest address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_stb_o | output | 1 | One-cycle pulse per register written |
| wr_idx_o | output | 8 | Index of the register written |
| wr_data_o | output | 8 | Byte written |
| regs_o | output | 96 | All register contents, 8 bits per slot |

## Verification
The bench drives bursts that run past offset 0xF, and a burst that starts at 0x11. With these it shows that the index wraps inside its page. A design that carried into the page nibble would return or overwrite page-1 registers, or skip back to offset 0 of the wrong page. Writes and reads at holes in the map (0x0A, 0x0F, 0x13) would expose a decoder that aliases or strobes unimplemented indices. After a NACK, the bench clocks a whole byte and expects it to read as all ones. A target that kept sending would pull bits low. The bench also aborts a transfer with a START inside a byte, ends one with a STOP before any data, and sends an address whose strap bit is wrong. A controller that failed to resynchronise, or that matched too loosely, would then acknowledge bytes it should ignore.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_IDX,
        PH_DATA
    } ph_e;

    // Offset advance that never touches the page nibble
    function automatic logic [7:0] nib_inc(input logic [7:0] idx);
        return {idx[7:4], idx[3:0] + 4'd1};
    endfunction

    // Index held by a register slot: page 0 first, then page 1
    function automatic logic [7:0] slot_index(input int s, input int p0);
        return (s < p0) ? 8'(s) : 8'(16 + s - p0);
    endfunction

    function automatic logic is_impl(input logic [7:0] idx, input int p0, input int p1);
        return ((idx[7:4] == 4'h0) && (32'(idx[3:0]) < p0)) ||
               ((idx[7:4] == 4'h1) && (32'(idx[3:0]) < p1));
    endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sy_t;

    sy_t q, d;

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = q.scl[STAGES-1];
        d.sda_p = q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s    = q.scl[STAGES-1];
    assign sda_s    = q.sda[STAGES-1];
    assign scl_rise = scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s & q.scl_p;
    assign start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ev && stop_ev) && !(scl_rise && scl_fall)); // R8

endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
    import i2cr_pkg::*;
#(
    parameter int          P0_REGS = 9,
    parameter int          P1_REGS = 3,
    parameter logic [7:0]  RST_XOR = 8'h5A,
    localparam int         NREGS   = P0_REGS + P1_REGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NREGS*8-1:0] regs_o
);
    logic [7:0]       regs_q [NREGS];
    logic [7:0]       regs_d [NREGS];
    logic [NREGS-1:0] wsel;

    for (genvar s = 0; s < NREGS; s++) begin : g_slot
        localparam logic [7:0] SIDX = slot_index(s, P0_REGS);
        assign wsel[s]            = wr_en && (wr_idx == SIDX);
        assign regs_d[s]          = wsel[s] ? wr_data : regs_q[s];
        assign regs_o[s*8 +: 8]   = regs_q[s];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[s] <= SIDX ^ RST_XOR;
            else        regs_q[s] <= regs_d[s];
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int s = 0; s < NREGS; s++) begin
            if (rd_idx == slot_index(s, P0_REGS)) rd_data = regs_q[s];
        end
    end

    AST_WR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $onehot(wsel)); // R7
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (wsel == '0)); // R7

endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
    import i2cr_pkg::*;
#(
    parameter int         P0_REGS = 9,
    parameter int         P1_REGS = 3,
    parameter logic [5:0] ADDR_HI = 6'b010011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data
);
    typedef struct packed {
        st_e        st;
        ph_e        ph;
        logic [2:0] cnt;
        logic       done;
        logic [7:0] sh;
        logic       rw;
        logic [7:0] idx;
        logic       oe;
        logic       macked;
        logic       stb;
        logic [7:0] widx;
        logic [7:0] wdat;
    } ctl_t;

    ctl_t q, d;
    logic idx_ld;

    always_comb begin
        d      = q;
        d.stb  = 1'b0;
        idx_ld = 1'b0;
        if (start_ev) begin
            d.st   = ST_RX;
            d.ph   = PH_ADDR;
            d.cnt  = '0;
            d.done = 1'b0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st   = ST_IDLE;
            d.done = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && !q.done) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.done = 1'b1;
                    end else if (scl_fall && q.done) begin
                        d.done = 1'b0;
                        d.cnt  = '0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == {ADDR_HI, addr_sel}) begin
                                    d.rw = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = ST_ACK;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_IDX: begin
                                d.idx  = q.sh;
                                idx_ld = 1'b1;
                                d.oe   = 1'b1;
                                d.st   = ST_ACK;
                            end
                            default: begin
                                d.stb  = is_impl(q.idx, P0_REGS, P1_REGS);
                                d.widx = q.idx;
                                d.wdat = q.sh;
                                d.idx  = nib_inc(q.idx);
                                d.oe   = 1'b1;
                                d.st   = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.ph == PH_ADDR && q.rw) begin
                            d.st  = ST_TX;
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.idx = nib_inc(q.idx);
                        end else begin
                            d.st = ST_RX;
                            d.ph = (q.ph == PH_ADDR) ? PH_IDX : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.oe     = 1'b0;
                            d.macked = 1'b0;
                            d.st     = ST_RACK;
                        end else begin
                            d.cnt = q.cnt + 3'd1;
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.macked = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.macked) begin
                            d.st  = ST_TX;
                            d.cnt = '0;
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.idx = nib_inc(q.idx);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ph     <= PH_ADDR;
        end else begin
            q <= d;
        end
    end

    assign rd_idx  = q.idx;
    assign sda_oe  = q.oe;
    assign wr_stb  = q.stb;
    assign wr_idx  = q.widx;
    assign wr_data = q.wdat;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R1
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe); // R2
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_ld |=> $stable(q.idx[7:4])); // R6
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (q.st == ST_IDLE && !sda_oe)); // R8

endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
    import i2cr_pkg::*;
#(
    parameter int         P0_REGS = 9,
    parameter int         P1_REGS = 3,
    parameter logic [7:0] RST_XOR = 8'h5A,
    localparam int        NREGS   = P0_REGS + P1_REGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_sel_i,
    output logic               sda_oe_o,
    output logic               wr_stb_o,
    output logic [7:0]         wr_idx_o,
    output logic [7:0]         wr_data_o,
    output logic [NREGS*8-1:0] regs_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] rd_idx, rd_data;

    i2cr_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cr_ctrl #(
        .P0_REGS (P0_REGS),
        .P1_REGS (P1_REGS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .addr_sel (addr_sel_i),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe_o),
        .wr_stb   (wr_stb_o),
        .wr_idx   (wr_idx_o),
        .wr_data  (wr_data_o)
    );

    i2cr_regbank #(
        .P0_REGS (P0_REGS),
        .P1_REGS (P1_REGS),
        .RST_XOR (RST_XOR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb_o),
        .wr_idx  (wr_idx_o),
        .wr_data (wr_data_o),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: tb/i2cr_target_test.sv
module i2cr_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10 * CLK_PERIOD;
    localparam int NREGS      = 12;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_oe = 1'b0, addr_sel = 1'b0;
    logic sda_oe, wr_stb;
    logic [7:0] wr_idx, wr_data;
    logic [NREGS*8-1:0] regs;
    logic sda_line;

    int n_chk = 0, n_err = 0, stb_cnt = 0;
    logic [7:0] last_idx = 8'h00, last_dat = 8'h00;
    logic [7:0] mem [256];

    assign sda_line = !(m_oe || sda_oe);
    always #(CLK_PERIOD/2) clk = ~clk;

    i2cr_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
        .wr_idx_o(wr_idx), .wr_data_o(wr_data), .regs_o(regs)
    );

    always @(posedge clk) if (rst_n && wr_stb) begin
        stb_cnt  <= stb_cnt + 1;
        last_idx <= wr_idx;
        last_dat <= wr_data;
    end

    function automatic bit impl(input logic [7:0] i);
        return (i <= 8'h08) || (i >= 8'h10 && i <= 8'h12);
    endfunction
    function automatic logic [7:0] nx(input logic [7:0] i);
        return {i[7:4], i[3:0] + 4'd1};
    endfunction
    function automatic logic [7:0] slot_val(input int s);
        return regs[s*8 +: 8];
    endfunction
    function automatic logic [7:0] idx_of(input int s);
        return (s < 9) ? 8'(s) : 8'(16 + s - 9);
    endfunction
    function automatic logic [7:0] adr(input logic x, input logic rw);
        return {6'b010011, x, rw};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic bit_out(input logic b);
        m_oe = !b; #(Q); scl = 1'b1; #(Q); #(Q); scl = 1'b0; #(Q);
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_oe = 1'b0; #(Q); scl = 1'b1; #(Q); ack = (sda_line == 1'b0); #(Q); scl = 1'b0; #(Q);
    endtask
    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_oe = 1'b0; #(Q); scl = 1'b1; #(Q); b[i] = sda_line; #(Q); scl = 1'b0; #(Q);
        end
        m_oe = mack; #(Q); scl = 1'b1; #(Q); #(Q); scl = 1'b0; #(Q); m_oe = 1'b0;
    endtask
    task automatic i2c_start();
        m_oe = 1'b0; #(Q); scl = 1'b1; #(Q); m_oe = 1'b1; #(Q); scl = 1'b0; #(Q);
    endtask
    task automatic i2c_stop();
        m_oe = 1'b1; #(Q); scl = 1'b1; #(Q); m_oe = 1'b0; #(Q); #(Q);
    endtask

    // R3 R6 R7: write burst, model follows offset-only increment
    task automatic t_write(input logic [7:0] idx, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
        logic ack;
        logic [7:0] cur = idx;
        logic [7:0] db [3];
        int exp_stb = stb_cnt;
        db[0] = d0; db[1] = d1; db[2] = d2;
        i2c_start();
        send_byte(adr(addr_sel, 1'b0), ack); chk("R1 write address ack", ack, 1);
        send_byte(idx, ack);                 chk("R3 index ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(db[k], ack);           chk("R3 data ack", ack, 1);
            if (impl(cur)) begin mem[cur] = db[k]; exp_stb++; end
            cur = nx(cur);
        end
        i2c_stop();
        chk("R3 R7 strobe count", stb_cnt, exp_stb);
        for (int s = 0; s < NREGS; s++) chk("R3 R7 register contents", slot_val(s), mem[idx_of(s)]);
    endtask

    // R4 R5 R6 R7: combined-format read burst
    task automatic t_read(input logic [7:0] idx, input int n);
        logic ack;
        logic [7:0] b;
        logic [7:0] cur = idx;
        i2c_start();
        send_byte(adr(addr_sel, 1'b0), ack); chk("R1 address ack", ack, 1);
        send_byte(idx, ack);                 chk("R4 index ack", ack, 1);
        i2c_start();
        send_byte(adr(addr_sel, 1'b1), ack); chk("R4 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk("R4 R6 R7 read data", b, mem[cur]);
            cur = nx(cur);
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        logic ack;
        logic [7:0] b;
        for (int s = 0; s < NREGS; s++) chk("R9 reset value", slot_val(s), idx_of(s) ^ 8'h5A);
        chk("R9 SDA released", sda_oe, 0);
        i2c_start();
        send_byte(adr(1'b0, 1'b1), ack); chk("R9 read address ack", ack, 1);
        recv_byte(1'b0, b);
        chk("R9 index starts at 0x00", b, 8'h5A);
        i2c_stop();
    endtask

    task automatic t_wrong_addr();
        logic ack;
        i2c_start();
        send_byte(adr(1'b1, 1'b0), ack); chk("R2 mismatched address not acked", ack, 0);
        send_byte(8'h03, ack);           chk("R2 no ack after mismatch", ack, 0);
        send_byte(8'h11, ack);           chk("R2 no ack after mismatch", ack, 0);
        i2c_stop();
        chk("R2 register untouched", slot_val(3), mem[3]);
    endtask

    task automatic t_strap();
        addr_sel = 1'b1;
        #(Q);
        t_write(8'h01, 8'h7E, 8'h00, 8'h00, 1);
        t_read(8'h01, 1);
        addr_sel = 1'b0;
        #(Q);
    endtask

    task automatic t_nack_release();
        logic ack;
        logic [7:0] b;
        i2c_start();
        send_byte(adr(1'b0, 1'b0), ack);
        send_byte(8'h06, ack);
        i2c_start();
        send_byte(adr(1'b0, 1'b1), ack);
        recv_byte(1'b1, b); chk("R5 first byte", b, mem[8'h06]);
        recv_byte(1'b0, b); chk("R5 second byte", b, mem[8'h07]);
        recv_byte(1'b0, b); chk("R5 released after NACK", b, 8'hFF);
        i2c_stop();
    endtask

    task automatic t_start_stop();
        logic ack;
        // START inside a byte restarts address reception
        i2c_start();
        send_byte(adr(1'b0, 1'b0), ack);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        t_write(8'h04, 8'h9C, 8'h00, 8'h00, 1);
        chk("R8 restart write index", last_idx, 8'h04);
        chk("R8 restart write data", last_dat, 8'h9C);
        // STOP returns to idle; no new START means no ack
        i2c_start();
        send_byte(adr(1'b0, 1'b0), ack);
        send_byte(8'h05, ack);
        i2c_stop();
        scl = 1'b0; #(Q);
        send_byte(adr(1'b0, 1'b0), ack); chk("R8 idle after STOP", ack, 0);
        send_byte(8'h33, ack);           chk("R8 idle after STOP", ack, 0);
        i2c_stop();
        chk("R8 register 0x05 unchanged", slot_val(5), mem[8'h05]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = impl(8'(i)) ? (8'(i) ^ 8'h5A) : 8'h00;
        #(CLK_PERIOD * 5);
        rst_n = 1'b1;
        #(CLK_PERIOD * 5);
        t_reset();
        t_write(8'h03, 8'hC3, 8'h00, 8'h00, 1);
        chk("R3 strobe index", last_idx, 8'h03);
        chk("R3 strobe data", last_dat, 8'hC3);
        t_read(8'h03, 1);
        t_write(8'h06, 8'hA1, 8'hB2, 8'h44, 3);
        t_read(8'h05, 4);
        t_write(8'h0F, 8'hE7, 8'h19, 8'h00, 2);   // R6 R7: 0x0F hole, wraps to 0x00
        t_read(8'h0E, 3);                          // R6 R7: 0x0E, 0x0F read 0, then 0x00
        t_write(8'h0A, 8'h55, 8'h00, 8'h00, 1);   // R7 hole write
        t_write(8'h11, 8'h21, 8'h22, 8'h23, 3);   // R6 R7: 0x13 discarded, stays in page
        t_read(8'h10, 3);
        t_read(8'h1F, 2);                          // R6: wraps to 0x10, not 0x20
        t_wrong_addr();
        t_strap();
        t_nack_release();
        t_start_stop();
        summary();
    end
endmodule